// File: doc/BRIEF.md
# Counter Channel Programming and Readback Port

This block sits between a byte-wide register bus and a bank of up to three 16-bit down-counters. It owns the configuration of each counter (access mode, counting mode, BCD flag), sequences the byte-wide transfers of 16-bit count values, and keeps per-channel snapshots of the count and of a status byte so that software can read a stable value while the counter keeps running. The counters are external. They receive a one-cycle load strobe with the 16-bit value, and they present their live count and output level back to this block.

Two address bits select the target. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the shared command register. A command write reprograms one channel, snapshots one channel's count, or issues a read-back command that can snapshot count and status for any subset of channels in one write. Reads return data in the same cycle the read strobe is high. The channel state advances at the clock edge that ends the read.

Top module: `tmr_ctl_port`

## Requirements
- R1: A write to address 3 is a command: bits 7:6 pick the channel, bits 5:4 the access mode (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the counting mode and bit 0 BCD. With a nonzero access field, the channel's cfg_mode and cfg_bcd outputs take the new values after that clock edge. A command write never produces a load strobe.
- R2: Mode field values 6 and 7 are stored as modes 2 and 3.
- R3: A command whose access field is 0 snapshots the channel's live count and leaves its access mode, counting mode and BCD unchanged.
- R4: A command with channel field 3 is read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low requests a count snapshot and bit 4 low requests a status snapshot for every selected channel. Unselected channels are untouched.
- R5: The status byte is {output level, 0, access[1:0], mode[2:0], bcd}, taken at the command's clock edge.
- R6: A snapshot request for a channel that still holds an unread count snapshot (or an unread status snapshot) is ignored for that kind.
- R7: A data read returns the status snapshot first if one is held, then the count snapshot, and otherwise the live count. Each snapshot is released once it has been read out.
- R8: In low-then-high access, a count snapshot returns its low byte and then its high byte, and is released only after the second read.
- R9: In low-only access, a data write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}. load_stb for that channel is high for the one cycle after the write edge, with load_val valid in that cycle.
- R10: In low-then-high access, the first data write only stores the byte. The second loads {second, first} with a strobe.
- R11: Live reads return the low byte in low-only access and the high byte in high-only access. In low-then-high access they alternate, starting with the low byte.
- R12: A programming command resets that channel's read and write byte order to the low byte.
- R13: After reset, every channel is in low-then-high access, mode 0, binary, with no snapshots held, and no load strobe is active.
- R14: At most one bit of load_stb is high in any cycle, and only in the cycle after a data-port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | 0..2 channel data port, 3 command register |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high |
| cnt_live | input | NCH*16 | Live count of each counter, channel i at bits 16i+15:16i |
| out_lvl | input | NCH | Output level of each counter |
| load_stb | output | NCH | One-cycle load request per counter |
| load_val | output | 16 | Value to load, valid with a strobe |
| cfg_mode | output | NCH*3 | Counting mode per channel |
| cfg_bcd | output | NCH | BCD flag per channel |

## Verification
The bench builds the block with its default of three channels, so every data address and every read-back select bit maps to a real counter. This makes it possible to snapshot channels 0 and 2 together while leaving channel 1 untouched. It also lets each access mode be held on a different channel at the same time, so that low-only, high-only and alternating transfers are checked against each other, and the snapshot-versus-live ordering is checked on the alternating channel.

// File: rtl/tmr_pkg.sv
// Shared types for the counter programming port.
// Assumes byte-wide bus and 16-bit counters.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,   // command-only value; in snapshot state means "none held"
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    // Fold the two spare mode codes onto the periodic modes.
    function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
        return (m > 3'd5) ? m - 3'd4 : m;
    endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
// Command decoder: turns a write to the command address into per-channel
// program, count-snapshot and status-snapshot requests.
// Assumes at most one bus write per cycle; outputs are combinational.
module tmr_ctl_decode
    import tmr_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int CTRL_ADDR = 3
) (
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    prog,
    output logic [NCH-1:0]    snap_cnt,
    output logic [NCH-1:0]    snap_st,
    output acc_e              new_acc,
    output logic [MODE_W-1:0] new_mode,
    output logic              new_bcd
);
    logic       is_cmd;
    logic [1:0] sel;

    assign is_cmd   = wr_en && (addr == 2'(CTRL_ADDR));
    assign sel      = wdata[7:6];
    assign new_acc  = acc_e'(wdata[5:4]);
    assign new_mode = fold_mode(wdata[3:1]);
    assign new_bcd  = wdata[0];

    // Expand the command byte into per-channel request strobes.
    always_comb begin
        prog     = '0;
        snap_cnt = '0;
        snap_st  = '0;
        if (is_cmd) begin
            for (int i = 0; i < NCH; i++) begin
                if (sel == 2'd3) begin
                    if (wdata[i+1]) begin
                        snap_cnt[i] = !wdata[5];
                        snap_st[i]  = !wdata[4];
                    end
                end else if (int'(sel) == i) begin
                    if (new_acc == ACC_LATCH) snap_cnt[i] = 1'b1;
                    else                      prog[i]     = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
// Per-channel state: configuration, byte-order toggles, the low-byte holding
// register for word writes, and the count and status snapshots.
// Assumes a request strobe and a data-port access never hit it in one cycle.
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              snap_cnt,
    input  logic              snap_st,
    input  acc_e              new_acc,
    input  logic [MODE_W-1:0] new_mode,
    input  logic              new_bcd,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_bcd,
    output logic              st_held,
    output logic              cnt_held
);
    acc_e              acc_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] lo_hold_q;
    logic              st_vld_q;
    logic [BYTE_W-1:0] st_q;
    acc_e              cs_q;       // ACC_LATCH means no count snapshot
    logic [CNT_W-1:0]  cl_q;

    assign cfg_mode = mode_q;
    assign cfg_bcd  = bcd_q;
    assign st_held  = st_vld_q;
    assign cnt_held = (cs_q != ACC_LATCH);

    // Select the byte a read returns: status, then snapshot, then live.
    always_comb begin
        if (st_vld_q) begin
            rd_byte = st_q;
        end else if (cs_q == ACC_HI) begin
            rd_byte = cl_q[CNT_W-1:BYTE_W];
        end else if (cs_q != ACC_LATCH) begin
            rd_byte = cl_q[BYTE_W-1:0];
        end else begin
            unique case (acc_q)
                ACC_HI:   rd_byte = live[CNT_W-1:BYTE_W];
                ACC_WORD: rd_byte = rd_hi_q ? live[CNT_W-1:BYTE_W] : live[BYTE_W-1:0];
                default:  rd_byte = live[BYTE_W-1:0];
            endcase
        end
    end

    // Configuration and byte-order state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= ACC_WORD;
            mode_q    <= '0;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            lo_hold_q <= '0;
            ld_stb    <= 1'b0;
            ld_val    <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (prog) begin
                acc_q   <= new_acc;
                mode_q  <= new_mode;
                bcd_q   <= new_bcd;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end
            if (wr_hit) begin
                unique case (acc_q)
                    ACC_HI: begin
                        ld_stb <= 1'b1;
                        ld_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi_q) begin
                            lo_hold_q <= wdata;
                            wr_hi_q   <= 1'b1;
                        end else begin
                            ld_stb  <= 1'b1;
                            ld_val  <= {wdata, lo_hold_q};
                            wr_hi_q <= 1'b0;
                        end
                    end
                    default: begin
                        ld_stb <= 1'b1;
                        ld_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                endcase
            end
            if (rd_hit && !st_vld_q && cs_q == ACC_LATCH && acc_q == ACC_WORD)
                rd_hi_q <= !rd_hi_q;
        end
    end

    // Snapshot capture and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld_q <= 1'b0;
            st_q     <= '0;
            cs_q     <= ACC_LATCH;
            cl_q     <= '0;
        end else begin
            if (rd_hit) begin
                if (st_vld_q)              st_vld_q <= 1'b0;
                else if (cs_q == ACC_WORD) cs_q     <= ACC_HI;
                else                       cs_q     <= ACC_LATCH;
            end
            if (snap_st && !st_vld_q) begin
                st_vld_q <= 1'b1;
                st_q     <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
            end
            if (snap_cnt && cs_q == ACC_LATCH) begin
                cs_q <= acc_q;
                cl_q <= live;
            end
        end
    end
endmodule

// File: rtl/tmr_ctl_port.sv
// Top of the counter programming port: decodes the bus, instantiates one
// channel slice per counter and merges their read bytes and load requests.
// Assumes NCH <= 3, since address 3 is the command register.
module tmr_ctl_port
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH*CNT_W-1:0]  cnt_live,
    input  logic [NCH-1:0]        out_lvl,
    output logic [NCH-1:0]        load_stb,
    output logic [CNT_W-1:0]      load_val,
    output logic [NCH*MODE_W-1:0] cfg_mode,
    output logic [NCH-1:0]        cfg_bcd
);
    localparam int CTRL_ADDR = 3;

    logic [NCH-1:0]    prog, snap_cnt, snap_st;
    acc_e              new_acc;
    logic [MODE_W-1:0] new_mode;
    logic              new_bcd;
    logic [BYTE_W-1:0] rd_byte [NCH];
    logic [CNT_W-1:0]  ld_val  [NCH];
    logic [NCH-1:0]    st_held_all, cnt_held_all;

    tmr_ctl_decode #(.NCH(NCH), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .prog(prog), .snap_cnt(snap_cnt), .snap_st(snap_st),
        .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan_port u_ch (
            .clk(clk), .rst_n(rst_n),
            .prog(prog[g]), .snap_cnt(snap_cnt[g]), .snap_st(snap_st[g]),
            .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd),
            .wr_hit(wr_en && addr == 2'(g)),
            .rd_hit(rd_en && addr == 2'(g)),
            .wdata(wdata),
            .live(cnt_live[g*CNT_W +: CNT_W]),
            .out_lvl(out_lvl[g]),
            .rd_byte(rd_byte[g]),
            .ld_stb(load_stb[g]),
            .ld_val(ld_val[g]),
            .cfg_mode(cfg_mode[g*MODE_W +: MODE_W]),
            .cfg_bcd(cfg_bcd[g]),
            .st_held(st_held_all[g]),
            .cnt_held(cnt_held_all[g])
        );
    end

    // Route the addressed channel's byte to the bus; command address reads 0.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (rd_en && addr == 2'(i)) rdata = rd_byte[i];
    end

    // Present the value of whichever channel is strobing.
    always_comb begin
        load_val = '0;
        for (int i = 0; i < NCH; i++)
            if (load_stb[i]) load_val = ld_val[i];
    end
endmodule

// File: rtl/tmr_ctl_port_chk.sv
// Checker for the counter programming port, bound to the top module.
// Assumes the bus never raises rd_en and wr_en in the same cycle.
module tmr_ctl_port_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic [1:0]     addr,
    input logic [NCH-1:0] load_stb,
    input logic [NCH-1:0] st_held,
    input logic [NCH-1:0] cnt_held
);
    a_r14_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    a_r14_load_after_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |-> $past(wr_en && addr != 2'd3));

    a_r1_cmd_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> (load_stb == '0));

    a_r7_status_held_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held[0] && !(rd_en && addr == 2'd0)) |=> st_held[0]);

    a_r7_status_released_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held[0] && rd_en && !wr_en && addr == 2'd0) |=> !st_held[0]);

    a_r7_count_waits_for_status: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held[0] && cnt_held[0] && rd_en && !wr_en && addr == 2'd0) |=> cnt_held[0]);
endmodule

bind tmr_ctl_port tmr_ctl_port_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .load_stb(load_stb), .st_held(st_held_all), .cnt_held(cnt_held_all)
);

// File: tb/tmr_ctl_port_tb.sv
// Directed bench for the counter programming port.
module tmr_ctl_port_tb;
    localparam int NCH = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [1:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic [NCH*16-1:0] cnt_live = '0;
    logic [NCH-1:0]   out_lvl = '0;
    logic [NCH-1:0]   load_stb;
    logic [15:0]      load_val;
    logic [NCH*3-1:0] cfg_mode;
    logic [NCH-1:0]   cfg_bcd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [NCH-1:0] last_stb;
    logic [15:0]    last_val;

    always #4 clk = !clk;   // 125 MHz

    tmr_ctl_port #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_live(cnt_live), .out_lvl(out_lvl),
        .load_stb(load_stb), .load_val(load_val), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_stb = load_stb;
        last_val = load_val;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        cnt_live[ch*16 +: 16] = v;
    endtask

    task automatic t_reset;
        logic [7:0] b;
        chk("R13 modes", 16'(cfg_mode), 16'h0);
        chk("R13 bcd", 16'(cfg_bcd), 16'h0);
        chk("R13 no strobe", 16'(load_stb), 16'h0);
        set_live(0, 16'h1234);
        rd(2'd0, b); chk("R13 R11 word live low first", 16'(b), 16'h34);
        rd(2'd0, b); chk("R11 word live high second", 16'(b), 16'h12);
        rd(2'd0, b); chk("R11 word live back to low", 16'(b), 16'h34);
    endtask

    task automatic t_program;
        wr(2'd3, 8'b01_01_011_1);   // ch1 low-only, mode 3, BCD
        chk("R1 ch1 mode", 16'(cfg_mode[5:3]), 16'd3);
        chk("R1 ch1 bcd", 16'(cfg_bcd[1]), 16'd1);
        chk("R1 cmd no strobe", 16'(last_stb), 16'h0);
        wr(2'd3, 8'b10_11_110_0);   // ch2 word, mode 6 -> 2
        chk("R2 mode6 folds to 2", 16'(cfg_mode[8:6]), 16'd2);
        wr(2'd3, 8'b00_10_111_0);   // ch0 high-only, mode 7 -> 3
        chk("R2 mode7 folds to 3", 16'(cfg_mode[2:0]), 16'd3);
        chk("R1 ch0 bcd clear", 16'(cfg_bcd[0]), 16'd0);
    endtask

    task automatic t_writes;
        wr(2'd1, 8'h5A);
        chk("R9 low-only strobe", 16'(last_stb), 16'b010);
        chk("R9 low-only value", last_val, 16'h005A);
        wr(2'd0, 8'h77);
        chk("R9 high-only strobe", 16'(last_stb), 16'b001);
        chk("R9 high-only value", last_val, 16'h7700);
        wr(2'd2, 8'h11);
        chk("R10 first byte no strobe", 16'(last_stb), 16'h0);
        wr(2'd2, 8'h22);
        chk("R10 second byte strobe", 16'(last_stb), 16'b100);
        chk("R10 word value", last_val, 16'h2211);
    endtask

    task automatic t_live;
        logic [7:0] b;
        set_live(1, 16'hC3A5);
        set_live(0, 16'h9E10);
        rd(2'd1, b); chk("R11 low-only read", 16'(b), 16'hA5);
        rd(2'd1, b); chk("R11 low-only read again", 16'(b), 16'hA5);
        rd(2'd0, b); chk("R11 high-only read", 16'(b), 16'h9E);
    endtask

    task automatic t_latch;
        logic [7:0] b;
        set_live(2, 16'hABCD);
        wr(2'd3, 8'b10_00_0000);
        chk("R3 config kept", 16'(cfg_mode[8:6]), 16'd2);
        set_live(2, 16'h1111);
        rd(2'd2, b); chk("R8 R3 snapshot low", 16'(b), 16'hCD);
        set_live(2, 16'h2222);
        wr(2'd3, 8'b10_00_0000);    // ignored: snapshot still half-read
        rd(2'd2, b); chk("R6 R8 snapshot high", 16'(b), 16'hAB);
        rd(2'd2, b); chk("R7 live after release", 16'(b), 16'h22);
    endtask

    task automatic t_readback;
        logic [7:0] b;
        out_lvl = 3'b101;
        set_live(0, 16'hBEEF);
        set_live(2, 16'h4321);
        set_live(1, 16'h0F0E);
        wr(2'd3, 8'hCA);            // channels 0 and 2, count and status
        set_live(0, 16'h5566);
        set_live(2, 16'h7788);
        rd(2'd0, b); chk("R5 R7 ch0 status first", 16'(b), 16'hA6);
        rd(2'd0, b); chk("R4 ch0 count snapshot high", 16'(b), 16'hBE);
        rd(2'd0, b); chk("R7 ch0 live afterwards", 16'(b), 16'h55);
        rd(2'd2, b); chk("R5 ch2 status", 16'(b), 16'hB4);
        rd(2'd2, b); chk("R8 ch2 snapshot low", 16'(b), 16'h21);
        rd(2'd2, b); chk("R8 ch2 snapshot high", 16'(b), 16'h43);
        rd(2'd1, b); chk("R4 ch1 unselected live", 16'(b), 16'h0E);
        wr(2'd3, 8'hE4);            // ch1 status only
        out_lvl = 3'b111;
        wr(2'd3, 8'hE4);            // ignored: status unread
        rd(2'd1, b); chk("R6 R5 ch1 first status kept", 16'(b), 16'h17);
        rd(2'd1, b); chk("R4 status-only leaves no count", 16'(b), 16'h0E);
    endtask

    task automatic t_toggle_reset;
        logic [7:0] b;
        wr(2'd2, 8'h33);            // half of a word write
        set_live(2, 16'h6A5B);
        rd(2'd2, b);                // low byte; next would be high
        wr(2'd3, 8'b10_11_010_0);   // reprogram ch2
        rd(2'd2, b); chk("R12 read order restarts low", 16'(b), 16'h5B);
        wr(2'd2, 8'h44);
        chk("R12 first write after reprogram holds", 16'(last_stb), 16'h0);
        wr(2'd2, 8'h55);
        chk("R12 word write restarts low", last_val, 16'h5544);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_writes();
        t_live();
        t_latch();
        t_readback();
        t_toggle_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule